// File: doc/BRIEF.md
# Segment-Grouping Memory Request Coalescer

This block takes one batch of sixteen lane requests (an active flag and a byte address per lane) together with one word size shared by the whole batch: 2, 4, 8 or 16 bytes. It turns the batch into a short series of memory transactions. On each pass it takes the lowest-numbered lane that is still pending and finds the aligned segment that holds that lane's address. Every pending lane that falls into the same segment joins the group. The transaction is then shrunk to the smallest aligned half, or quarter, of the segment that still covers every byte the group touches.

Each transaction leaves the block as a descriptor holding a base address, a size in bytes and a 16-bit mask of the lanes it serves. Descriptors are handed over on a valid/ready handshake. When the last one has been accepted, a one-cycle done pulse follows. A new batch is taken with a start pulse while the block is idle. Lane addresses are assumed to be aligned to the word size.

Top module: `seg_merge_unit`

## Requirements
- R1: The word-size code selects both the word width and the segment width. Code 0 means 2-byte words in 32-byte segments, code 1 means 4-byte words in 64-byte segments, code 2 means 8-byte words in 128-byte segments, and code 3 means 16-byte words in 128-byte segments. A segment base is the lane address with its low bits cleared down to the segment width.
- R2: Each descriptor is built around the lowest-numbered lane that is still pending. Its mask holds that lane and every other pending lane whose address lies in the same segment. Descriptors come out in increasing order of their leading lane.
- R3: A batch whose active lanes touch N distinct segments produces exactly N descriptors. Every active lane appears in exactly one mask, and no inactive lane appears in any mask. Mask bit i stands for lane i.
- R4: When every byte the group uses lies in only the lower or only the upper 64-byte half of a 128-byte segment, the descriptor covers only that half: 64 bytes, based at the start of that half.
- R5: The same halving is applied to a 64-byte region, down to 32 bytes, which is the smallest size. The size field is always 32, 64 or 128, and the base is always a multiple of the size.
- R6: Lane i uses the bytes from its address up to its address plus the word size minus one. A group whose bytes cross the midpoint of a region keeps the whole region. The leading lane's bytes always lie inside the descriptor.
- R7: While `txn_valid` is high and `txn_ready` is low, the descriptor holds its base, size and mask unchanged and stays valid.
- R8: `done` is high for exactly one cycle. That cycle is the one right after the clock edge that accepts the final descriptor. A start with no active lanes gives `done` in the cycle after the start edge and no descriptor. `done` and `txn_valid` are never high together.
- R9: A start pulse while `busy` is high is ignored. The batch in progress keeps its lanes, addresses and word size.
- R10: After reset, `busy`, `txn_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Takes a new batch when idle |
| wsize_in | input | 2 | Word-size code (0:2 B, 1:4 B, 2:8 B, 3:16 B) |
| act_in | input | 16 | Active flag per lane |
| addr_in | input | 512 | Byte address per lane; lane i in bits [32i+31:32i] |
| busy | output | 1 | A batch is being issued |
| txn_valid | output | 1 | A descriptor is on offer |
| txn_ready | input | 1 | The consumer takes the descriptor |
| txn_base | output | 32 | Transaction base address |
| txn_bytes | output | 8 | Transaction size in bytes |
| txn_mask | output | 16 | Lanes served by this transaction |
| done | output | 1 | One-cycle pulse after the batch's final descriptor |

## Verification
A wrong pending mask shows at the ports as soon as the next descriptor is offered. It shows up as a lane served twice, a lane never served, or an extra or missing descriptor before `done`. A wrong leader or segment match shows in the same handshake as a descriptor whose base, order or mask differs from a segment-by-segment recomputation. A wrong trim shows there too, as the wrong size or offset. Errors in the handshake or in the end-of-batch logic show within one cycle: a stalled descriptor that changes, or a `done` pulse that is late, early or repeated.

// File: rtl/seg_merge_pkg.sv
package seg_merge_pkg;
  // bytes per lane word for a word-size code
  function automatic logic [7:0] word_bytes(input logic [1:0] code);
    return 8'd2 << code;
  endfunction

  // aligned segment width for a word-size code
  function automatic logic [7:0] seg_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 8'd32;
      2'd1:    return 8'd64;
      default: return 8'd128;
    endcase
  endfunction
endpackage

// File: rtl/lane_pick.sv
module lane_pick #(
  parameter int LANES = 16,
  localparam int LW = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend,
  output logic [LANES-1:0] lead_oh,
  output logic [LW-1:0]    lead_idx
);
  always_comb begin
    lead_oh  = '0;
    lead_idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        lead_oh  = '0;
        lead_oh[i] = 1'b1;
        lead_idx = LW'(i);
      end
    end
  end
endmodule

// File: rtl/seg_match.sv
module seg_match #(
  parameter int AW = 32,
  parameter int LANES = 16
) (
  input  logic [LANES-1:0]    pend,
  input  logic [LANES*AW-1:0] addr_flat,
  input  logic [AW-1:0]       seg_base,
  input  logic [AW-1:0]       seg_mask,
  input  logic [7:0]          wbytes,
  output logic [LANES-1:0]    grp,
  output logic [7:0]          lo_off,
  output logic [7:0]          hi_end
);
  logic [7:0] off_a [LANES];
  logic [7:0] end_a [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [AW-1:0] a_i;
    assign a_i      = addr_flat[i*AW +: AW];
    assign grp[i]   = pend[i] && ((a_i & ~seg_mask) == seg_base);
    assign off_a[i] = a_i[7:0] & seg_mask[7:0];
    assign end_a[i] = off_a[i] + wbytes;
  end

  // lowest used offset and one past the highest used byte within the segment
  always_comb begin
    lo_off = 8'hFF;
    hi_end = 8'h00;
    for (int i = 0; i < LANES; i++) begin
      if (grp[i]) begin
        if (off_a[i] < lo_off) lo_off = off_a[i];
        if (end_a[i] > hi_end) hi_end = end_a[i];
      end
    end
  end
endmodule

// File: rtl/txn_trim.sv
module txn_trim #(
  parameter int AW = 32,
  parameter int MAX_SEG = 128,
  parameter int MIN_TXN = 32,
  localparam int STEPS = $clog2(MAX_SEG / MIN_TXN)
) (
  input  logic [AW-1:0] seg_base,
  input  logic [7:0]    seg_sz,
  input  logic [7:0]    lo_off,
  input  logic [7:0]    hi_end,
  output logic [AW-1:0] txn_base,
  output logic [7:0]    txn_bytes
);
  logic [7:0] o, sz, half;

  always_comb begin
    o    = 8'd0;
    sz   = seg_sz;
    half = 8'd0;
    for (int k = 0; k < STEPS; k++) begin
      if (sz > 8'(MIN_TXN)) begin
        half = sz >> 1;
        if (hi_end <= o + half) begin
          sz = half;
        end else if (lo_off >= o + half) begin
          o  = o + half;
          sz = half;
        end
      end
    end
    txn_base  = seg_base | {{(AW-8){1'b0}}, o};
    txn_bytes = sz;
  end
endmodule

// File: rtl/seg_merge_unit.sv
module seg_merge_unit
  import seg_merge_pkg::*;
#(
  parameter int AW = 32,
  parameter int LANES = 16,
  localparam int LW = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          wsize_in,
  input  logic [LANES-1:0]    act_in,
  input  logic [LANES*AW-1:0] addr_in,
  output logic                busy,
  output logic                txn_valid,
  input  logic                txn_ready,
  output logic [AW-1:0]       txn_base,
  output logic [7:0]          txn_bytes,
  output logic [LANES-1:0]    txn_mask,
  output logic                done
);
  logic                busy_q, done_q;
  logic [LANES-1:0]    pend_q;
  logic [LANES*AW-1:0] addr_q;
  logic [1:0]          code_q;

  // named internal events for the checks
  logic [LANES-1:0] lead_oh, grp, left_after;
  logic [LW-1:0]    lead_idx;
  logic [AW-1:0]    lead_addr, seg_base, seg_mask;
  logic [7:0]       seg_sz, wb, lo_off, hi_end;
  logic             hs, last_hs, take;

  lane_pick #(.LANES(LANES)) u_pick (
    .pend(pend_q), .lead_oh(lead_oh), .lead_idx(lead_idx)
  );

  assign seg_sz    = seg_bytes(code_q);
  assign wb        = word_bytes(code_q);
  assign seg_mask  = AW'(seg_sz) - AW'(1);
  assign lead_addr = addr_q[int'(lead_idx)*AW +: AW];
  assign seg_base  = lead_addr & ~seg_mask;

  seg_match #(.AW(AW), .LANES(LANES)) u_match (
    .pend(pend_q), .addr_flat(addr_q), .seg_base(seg_base), .seg_mask(seg_mask),
    .wbytes(wb), .grp(grp), .lo_off(lo_off), .hi_end(hi_end)
  );

  txn_trim #(.AW(AW)) u_trim (
    .seg_base(seg_base), .seg_sz(seg_sz), .lo_off(lo_off), .hi_end(hi_end),
    .txn_base(txn_base), .txn_bytes(txn_bytes)
  );

  assign txn_valid  = busy_q;
  assign txn_mask   = grp;
  assign busy       = busy_q;
  assign done       = done_q;
  assign hs         = txn_valid && txn_ready;
  assign left_after = pend_q & ~grp;
  assign last_hs    = hs && (left_after == '0);
  assign take       = start && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pend_q <= '0;
      addr_q <= '0;
      code_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (take) begin
        pend_q <= act_in;
        addr_q <= addr_in;
        code_q <= wsize_in;
        busy_q <= |act_in;
        done_q <= ~|act_in;
      end else if (hs) begin
        pend_q <= left_after;
        if (last_hs) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  // R2
  lead_in_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (lead_oh != '0) && ((grp & lead_oh) == lead_oh));
  // R3
  group_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((grp & ~pend_q) == '0));
  // R5
  size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_bytes inside {8'd32, 8'd64, 8'd128}) &&
                  ((txn_base & (AW'(txn_bytes) - AW'(1))) == '0));
  // R6
  lead_covered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (lead_addr >= txn_base) &&
                  (lead_addr + AW'(wb) <= txn_base + AW'(txn_bytes)));
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) &&
                                $stable(txn_bytes) && $stable(txn_mask));
  // R8
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !txn_valid);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !hs |=> $stable(pend_q) && $stable(code_q));
endmodule

// File: tb/seg_merge_unit_test.sv
module seg_merge_unit_test;
  localparam int PERIOD = 10;
  localparam int AW = 32;
  localparam int LANES = 16;
  localparam int DW = AW + 8 + LANES;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, txn_ready = 1'b0;
  logic [1:0] wsize_in = '0;
  logic [LANES-1:0] act_in = '0;
  logic [LANES*AW-1:0] addr_in = '0;
  logic busy, txn_valid, done;
  logic [AW-1:0] txn_base;
  logic [7:0] txn_bytes;
  logic [LANES-1:0] txn_mask;

  seg_merge_unit #(.AW(AW), .LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wsize_in(wsize_in), .act_in(act_in),
    .addr_in(addr_in), .busy(busy), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_base(txn_base), .txn_bytes(txn_bytes), .txn_mask(txn_mask), .done(done)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, last_hs_at = -1;
  bit slow = 1'b0;
  logic [AW-1:0] a [LANES];
  logic [DW-1:0] exp_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  // independent model: chunk-based span per segment
  task automatic build_expect(input logic [1:0] code, input logic [LANES-1:0] act);
    logic [LANES-1:0] left, grp;
    int seg, wb, ld, lo, hi, fc, lc, sz;
    logic [AW-1:0] base, tb;
    left = act;
    seg = (code == 2'd0) ? 32 : (code == 2'd1) ? 64 : 128;
    wb = 2 << code;
    while (left != '0) begin
      ld = 0;
      for (int i = LANES - 1; i >= 0; i--) if (left[i]) ld = i;
      base = (a[ld] / seg) * seg;
      grp = '0; lo = 1000; hi = 0;
      for (int i = 0; i < LANES; i++) begin
        if (left[i] && (a[i] / seg == a[ld] / seg)) begin
          grp[i] = 1'b1;
          if (int'(a[i] - base) < lo) lo = int'(a[i] - base);
          if (int'(a[i] - base) + wb > hi) hi = int'(a[i] - base) + wb;
        end
      end
      fc = lo / 32; lc = (hi - 1) / 32;
      if (fc == lc) sz = 32;
      else if (fc / 2 == lc / 2) sz = 64;
      else sz = 128;
      tb = base + AW'((fc / (sz / 32)) * sz);
      exp_q.push_back({tb, 8'(sz), grp});
      left &= ~grp;
    end
  endtask

  task automatic run_case(input string tag, input logic [1:0] code,
                          input logic [LANES-1:0] act, input bit intrude);
    int st_cyc, n, want;
    build_expect(code, act);
    @(negedge clk);
    wsize_in = code; act_in = act;
    for (int i = 0; i < LANES; i++) addr_in[i*AW +: AW] = a[i];
    start = 1'b1; st_cyc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (intrude) begin
      @(negedge clk);
      chk(busy, $sformatf("%s R9 busy before intrusion actual=%0b expected=1", tag, busy));
      act_in = ~act; wsize_in = ~code; addr_in = ~addr_in; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    #1;
    while (!done && n < 400) begin
      @(negedge clk); #1; n++;
    end
    chk(done, $sformatf("%s R8 done seen actual=%0b expected=1", tag, done));
    want = (act == '0) ? st_cyc + 1 : last_hs_at;
    chk(cyc == want, $sformatf("%s R8 done cycle actual=%0d expected=%0d", tag, cyc, want));
    chk(exp_q.size() == 0, $sformatf("%s R3 descriptors left unissued actual=%0d expected=0",
                                     tag, exp_q.size()));
    exp_q.delete();
    @(negedge clk); #1;
    chk(!done, $sformatf("%s R8 done width actual=%0b expected=0", tag, done));
  endtask

  // ready pattern
  int rc = 0;
  always @(negedge clk) begin
    rc <= rc + 1;
    txn_ready <= slow ? (rc % 3 != 0) : 1'b1;
  end

  // monitor / scoreboard
  logic prev_stall = 1'b0;
  logic [DW-1:0] prev_d = '0;
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (prev_stall)
          chk(txn_valid && {txn_base, txn_bytes, txn_mask} == prev_d,
              $sformatf("R7 stalled descriptor actual=%h expected=%h",
                        {txn_base, txn_bytes, txn_mask}, prev_d));
        if (txn_valid && txn_ready) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, $sformatf("R3 extra descriptor actual=%h expected=none",
                                {txn_base, txn_bytes, txn_mask}));
          end else begin
            logic [DW-1:0] e;
            e = exp_q.pop_front();
            chk({txn_base, txn_bytes, txn_mask} == e,
                $sformatf("R2 R4 R5 R6 descriptor actual=%h expected=%h",
                          {txn_base, txn_bytes, txn_mask}, e));
          end
          last_hs_at = cyc + 1;
        end
        prev_stall = txn_valid && !txn_ready;
        prev_d = {txn_base, txn_bytes, txn_mask};
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8 actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !txn_valid && !done,
        $sformatf("R10 reset state actual=%b%b%b expected=000", busy, txn_valid, done));
    rst_n = 1'b1;

    // R1: 4-byte words fill one 64-byte segment
    for (int i = 0; i < LANES; i++) a[i] = 32'h1000 + 4 * i;
    run_case("r1_w4", 2'd1, 16'hFFFF, 1'b0);
    // R1: 2-byte words fill one 32-byte segment
    for (int i = 0; i < LANES; i++) a[i] = 32'h2000 + 2 * i;
    run_case("r1_w2", 2'd0, 16'hFFFF, 1'b0);
    // R1: 16-byte words span two 128-byte segments
    for (int i = 0; i < LANES; i++) a[i] = 32'h2800 + 16 * i;
    run_case("r1_w16", 2'd3, 16'hFFFF, 1'b0);
    // R4: lower half of a 128-byte segment
    for (int i = 0; i < LANES; i++) a[i] = 32'h3000 + 8 * (i % 8);
    run_case("r4_low", 2'd2, 16'h00FF, 1'b0);
    // R4: upper half, repeated addresses allowed
    for (int i = 0; i < LANES; i++) a[i] = 32'h3040 + 8 * (i % 8);
    run_case("r4_high", 2'd2, 16'hFFFF, 1'b0);
    // R5: upper 32 bytes of a 64-byte segment
    for (int i = 0; i < LANES; i++) a[i] = 32'h4020 + 4 * (i % 8);
    run_case("r5_quarter", 2'd1, 16'hFFFF, 1'b0);
    // R6: 16-byte lanes straddle the midpoint -> whole 128
    a[0] = 32'h7030; a[1] = 32'h7040;
    run_case("r6_straddle", 2'd3, 16'h0003, 1'b0);
    // R6: single 16-byte lane in one 32-byte quarter
    run_case("r6_single16", 2'd3, 16'h0001, 1'b0);
    // R6: single 8-byte lane at offset 56 -> quarter at 0x7020
    a[0] = 32'h7038;
    run_case("r6_single8", 2'd2, 16'h0001, 1'b0);
    // R2 R3: scattered lanes with back-pressure
    slow = 1'b1;
    for (int i = 0; i < LANES; i++)
      a[i] = (i % 3 == 0) ? 32'h9000 + 4 * (15 - i) :
             (i % 3 == 1) ? 32'hA040 + 4 * i : 32'hB000 + 64 * i;
    run_case("r2_r3_scatter", 2'd1, 16'b1011_0111_1110_1101, 1'b0);
    // R9 R3: sixteen segments, start pulse while busy
    for (int i = 0; i < LANES; i++) a[i] = 32'hC000 + 32 * (15 - i);
    run_case("r9_intrude", 2'd0, 16'hFFFF, 1'b1);
    slow = 1'b0;
    // R8: empty batch
    run_case("r8_empty", 2'd1, 16'h0000, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule